// File: doc/BRIEF.md
# GPIO Output Blink Overlay

This block sits between the per-pin GPIO configuration (direction, stored output level, native-function select) and the pad drivers of a 32-pin bank. For each pin it can replace the level that would be driven with a slow square wave of about one hertz, or with a repeating serial pattern driven in open-drain fashion (pulled low or released, never actively driven high). The stored output level is only an input here. It is never written, so clearing an enable restores the pin's earlier level at once.

Two 32-bit enable words, one for plain blink and one for serial blink, are reached through a small write/read port. One timebase drives every blinking pin, so all of them toggle in phase. A second divided tick steps the serial pattern. The enable words have a reset-domain rule. A resume reset, or a write to the platform reset-control register, returns them to their defaults and restarts both timebases. A platform reset on its own leaves them and the timebases alone. The default blink word has bit 18 set, so pin 18 blinks from reset until firmware clears it after a good boot.

Top module: `gpio_blink_ovl`

## Requirements
- R1: After a resume reset (`rst_n` low at a clock edge) the blink word reads 0x00040000 and the serial word reads 0, so pin 18 blinks when it is a non-native output.
- R2: A non-native output pin with its blink bit set has `pad_oe`=1 and `pad_do` equal to a square wave. The wave holds each level for `HALF_CYCLES` clocks and is high for the first half-period after every restore. All blinking pins are in phase.
- R3: Neither enable bit has any effect on a pin whose `pin_is_out` is 0. Such a pin has `pad_oe`=0 and `pad_do`=`pin_level`.
- R4: `pad_do` of a blinking pin does not depend on `pin_level`. As soon as the enables are cleared, the pin drives `pin_level` again.
- R5: A non-native output pin with its serial bit set and its blink bit clear has `pad_do`=0 and `pad_oe` equal to the inverse of the current pattern bit. The pattern bit index starts at 0 (LSB of `SER_PATTERN`) on restore, advances every `SER_DIV` clocks and wraps after `SER_LEN` bits.
- R6: When both enable bits of a pin are set, plain blink is applied and serial blink is ignored.
- R7: A serial-word write leaves the bits of pins whose `pin_native` is 1 unchanged. A read of the serial word returns 0 in those bit positions. A native pin passes `pin_is_out`/`pin_level` to `pad_oe`/`pad_do` untouched.
- R8: A `rst_ctl_wr` pulse restores both words to their defaults and restarts both timebases. It takes priority over a register write in the same cycle.
- R9: `plat_rst_n` low changes neither the enable words nor the blink phase. It clears only `reg_rdata`.
- R10: A read (`reg_rd`=1) returns the blink word for `reg_sel`=0 and the serial word for `reg_sel`=1 on `reg_rdata` one clock later. The value is held until the next read.
- R11: A write (`reg_wr`=1) loads `reg_wdata` into the word chosen by `reg_sel`, effective from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Resume reset, synchronous, active low |
| plat_rst_n | input | 1 | Platform reset, synchronous, active low |
| rst_ctl_wr | input | 1 | One-cycle pulse: write to platform reset-control register |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 1 | Word select: 0 blink, 1 serial blink |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| pin_is_out | input | 32 | Per-pin direction, 1 = output |
| pin_native | input | 32 | Per-pin native-function select |
| pin_level | input | 32 | Per-pin stored output level |
| pad_oe | output | 32 | Per-pin pad output enable |
| pad_do | output | 32 | Per-pin pad data |

## Verification
The assertions assume that `rst_ctl_wr` is a single-cycle pulse, that `reg_wr` and `reg_rd` are never both high, and that `pin_native` is stable across a serial write. The bench drives every input on the falling edge from one task at a time and pulses each strobe for exactly one cycle. It changes `pin_native` only while no write is in flight, so the stimulus stays inside these assumptions.

// File: rtl/gpio_blink_pkg.sv
// Shared types for the GPIO blink overlay.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package gpio_blink_pkg;

    // Selects which enable word the register port addresses.
    typedef enum logic {
        SEL_BLINK  = 1'b0,
        SEL_SERIAL = 1'b1
    } word_sel_e;

    // Counter width for a count range of v, never below one bit.
    function automatic int cnt_width(input int v);
        return (v <= 2) ? 1 : $clog2(v);
    endfunction

endpackage

// File: rtl/gpio_blink_timebase.sv
// Square-wave timebase shared by all blinking pins.
// Holds each level for HALF_CYCLES clocks and starts high after restore.
// Assumes: HALF_CYCLES >= 2; restore is synchronous.
module gpio_blink_timebase #(
    parameter int HALF_CYCLES = 125_000_000
) (
    input  logic clk,
    input  logic restore,
    output logic phase_o
);
    localparam int CW = gpio_blink_pkg::cnt_width(HALF_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Count clocks within a half period and flip the phase at its end.
    always_ff @(posedge clk) begin
        if (restore) begin
            cnt_q   <= '0;
            phase_o <= 1'b1;
        end else if (cnt_q == LAST) begin
            cnt_q   <= '0;
            phase_o <= ~phase_o;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/gpio_blink_serseq.sv
// Serial blink pattern sequencer. Steps through SER_PATTERN LSB first,
// one bit every SER_DIV clocks, and wraps after SER_LEN bits.
// Assumes: SER_DIV >= 2, SER_LEN >= 2; restore is synchronous.
module gpio_blink_serseq #(
    parameter int                 SER_DIV     = 12_500_000,
    parameter int                 SER_LEN     = 8,
    parameter logic [SER_LEN-1:0] SER_PATTERN = 8'b1011_0010
) (
    input  logic clk,
    input  logic restore,
    output logic bit_o
);
    localparam int DW = gpio_blink_pkg::cnt_width(SER_DIV);
    localparam int IW = gpio_blink_pkg::cnt_width(SER_LEN);
    localparam logic [DW-1:0] DIV_LAST = DW'(SER_DIV - 1);
    localparam logic [IW-1:0] IDX_LAST = IW'(SER_LEN - 1);

    logic [DW-1:0] div_q;
    logic [IW-1:0] idx_q;

    // Divide the clock down to the bit rate and advance the bit index.
    always_ff @(posedge clk) begin
        if (restore) begin
            div_q <= '0;
            idx_q <= '0;
        end else if (div_q == DIV_LAST) begin
            div_q <= '0;
            idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // Present the pattern bit at the current index.
    always_comb bit_o = SER_PATTERN[idx_q];
endmodule

// File: rtl/gpio_blink_enregs.sv
// Blink and serial-blink enable words. Restore loads the defaults and
// wins over a write. Serial bits of native pins are write-protected.
// Assumes: restore is synchronous; sel is valid whenever wr is high.
module gpio_blink_enregs #(
    parameter int              PINS          = 32,
    parameter logic [PINS-1:0] BLINK_DEFAULT = 32'h0004_0000
) (
    input  logic                     clk,
    input  logic                     restore,
    input  logic                     wr,
    input  gpio_blink_pkg::word_sel_e sel,
    input  logic [PINS-1:0]          wdata,
    input  logic [PINS-1:0]          native,
    output logic [PINS-1:0]          blink_q,
    output logic [PINS-1:0]          ser_q
);
    import gpio_blink_pkg::*;

    // Hold the blink word; restore takes priority over a write.
    always_ff @(posedge clk) begin
        if (restore)                     blink_q <= BLINK_DEFAULT;
        else if (wr && sel == SEL_BLINK) blink_q <= wdata;
    end

    // Hold the serial word; native pins keep their old bit on a write.
    always_ff @(posedge clk) begin
        if (restore)                      ser_q <= '0;
        else if (wr && sel == SEL_SERIAL) ser_q <= (wdata & ~native) | (ser_q & native);
    end
endmodule

// File: rtl/gpio_blink_padmux.sv
// Per-pin pad selection: native bypass, plain blink, open-drain serial,
// or normal drive. Plain blink has priority over serial blink.
// Assumes: all inputs are settled within the clock cycle.
module gpio_blink_padmux (
    input  logic is_out,
    input  logic native,
    input  logic level,
    input  logic blink_en,
    input  logic ser_en,
    input  logic phase,
    input  logic ser_bit,
    output logic oe,
    output logic dout
);
    // Choose the pad drive for this pin.
    always_comb begin
        oe   = is_out;
        dout = level;
        if (!native && is_out) begin
            if (blink_en) begin
                dout = phase;
            end else if (ser_en) begin
                oe   = ~ser_bit;
                dout = 1'b0;
            end
        end
    end
endmodule

// File: rtl/gpio_blink_ovl.sv
// Top of the GPIO output blink overlay for a bank of PINS pins.
// Resume reset and reset-control writes restore enables and timebases;
// platform reset only clears the read-data register.
// Assumes: synchronous active-low resets; one-cycle strobes.
module gpio_blink_ovl #(
    parameter int                 PINS          = 32,
    parameter logic [PINS-1:0]    BLINK_DEFAULT = 32'h0004_0000,
    parameter int                 HALF_CYCLES   = 125_000_000,
    parameter int                 SER_DIV       = 12_500_000,
    parameter int                 SER_LEN       = 8,
    parameter logic [SER_LEN-1:0] SER_PATTERN   = 8'b1011_0010
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            plat_rst_n,
    input  logic            rst_ctl_wr,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic            reg_sel,
    input  logic [PINS-1:0] reg_wdata,
    output logic [PINS-1:0] reg_rdata,
    input  logic [PINS-1:0] pin_is_out,
    input  logic [PINS-1:0] pin_native,
    input  logic [PINS-1:0] pin_level,
    output logic [PINS-1:0] pad_oe,
    output logic [PINS-1:0] pad_do
);
    import gpio_blink_pkg::*;

    logic            restore;
    logic            phase;
    logic            ser_bit;
    logic [PINS-1:0] blink_q;
    logic [PINS-1:0] ser_q;
    word_sel_e       sel;

    // Decode the restore condition and the word select.
    always_comb begin
        restore = !rst_n || rst_ctl_wr;
        sel     = word_sel_e'(reg_sel);
    end

    gpio_blink_timebase #(.HALF_CYCLES(HALF_CYCLES)) u_tb (
        .clk     (clk),
        .restore (restore),
        .phase_o (phase)
    );

    gpio_blink_serseq #(
        .SER_DIV     (SER_DIV),
        .SER_LEN     (SER_LEN),
        .SER_PATTERN (SER_PATTERN)
    ) u_ser (
        .clk     (clk),
        .restore (restore),
        .bit_o   (ser_bit)
    );

    gpio_blink_enregs #(
        .PINS          (PINS),
        .BLINK_DEFAULT (BLINK_DEFAULT)
    ) u_regs (
        .clk     (clk),
        .restore (restore),
        .wr      (reg_wr),
        .sel     (sel),
        .wdata   (reg_wdata),
        .native  (pin_native),
        .blink_q (blink_q),
        .ser_q   (ser_q)
    );

    // Register read data; cleared by either reset, native serial bits read 0.
    always_ff @(posedge clk) begin
        if (!rst_n || !plat_rst_n) reg_rdata <= '0;
        else if (reg_rd)           reg_rdata <= (sel == SEL_SERIAL) ? (ser_q & ~pin_native) : blink_q;
    end

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        gpio_blink_padmux u_mux (
            .is_out   (pin_is_out[p]),
            .native   (pin_native[p]),
            .level    (pin_level[p]),
            .blink_en (blink_q[p]),
            .ser_en   (ser_q[p]),
            .phase    (phase),
            .ser_bit  (ser_bit),
            .oe       (pad_oe[p]),
            .dout     (pad_do[p])
        );
    end
endmodule

// File: rtl/gpio_blink_chk.sv
// Assertion checker for gpio_blink_ovl, attached with bind below.
// Assumes: single-cycle rst_ctl_wr pulses; pin_native stable during writes.
module gpio_blink_chk #(
    parameter int              PINS          = 32,
    parameter logic [PINS-1:0] BLINK_DEFAULT = 32'h0004_0000
) (
    input logic            clk,
    input logic            rst_n,
    input logic            plat_rst_n,
    input logic            rst_ctl_wr,
    input logic            reg_wr,
    input logic            reg_sel,
    input logic [PINS-1:0] pin_is_out,
    input logic [PINS-1:0] pin_native,
    input logic [PINS-1:0] pad_oe,
    input logic [PINS-1:0] pad_do,
    input logic [PINS-1:0] blink_q,
    input logic [PINS-1:0] ser_q,
    input logic            phase
);
    logic [PINS-1:0] blink_act;
    logic [PINS-1:0] ser_act;

    // Derive which pins each overlay mode currently owns.
    always_comb begin
        blink_act = blink_q & pin_is_out & ~pin_native;
        ser_act   = ser_q & ~blink_q & pin_is_out & ~pin_native;
    end

    // R2
    blink_in_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & blink_act) == blink_act) &&
        (((pad_do & blink_act) == '0) || ((pad_do & blink_act) == blink_act)));

    // R3
    input_never_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~pin_is_out) == '0);

    // R5
    serial_open_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_act & pad_oe & pad_do) == '0);

    // R7
    native_serial_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel && !rst_ctl_wr) |=>
        (((ser_q ^ $past(ser_q)) & $past(pin_native)) == '0));

    // R8
    rstctl_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_ctl_wr |=> (blink_q == BLINK_DEFAULT) && (ser_q == '0) && phase);

    // R9
    plat_rst_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!plat_rst_n && !rst_ctl_wr && !reg_wr) |=> ($stable(blink_q) && $stable(ser_q)));
endmodule

bind gpio_blink_ovl gpio_blink_chk #(
    .PINS          (PINS),
    .BLINK_DEFAULT (BLINK_DEFAULT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .plat_rst_n (plat_rst_n),
    .rst_ctl_wr (rst_ctl_wr),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .pin_is_out (pin_is_out),
    .pin_native (pin_native),
    .pad_oe     (pad_oe),
    .pad_do     (pad_do),
    .blink_q    (blink_q),
    .ser_q      (ser_q),
    .phase      (phase)
);

// File: tb/tb_gpio_blink_ovl.sv
`timescale 1ns/1ps
// Directed bench for gpio_blink_ovl: one task per scenario.
module tb_gpio_blink_ovl;
    localparam int         PINS = 32;
    localparam int         HALF = 4;
    localparam int         SDIV = 3;
    localparam int         SLEN = 8;
    localparam logic [7:0] PAT  = 8'b1011_0010;
    localparam logic [31:0] DEF = 32'h0004_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        plat_rst_n = 1'b1;
    logic        rst_ctl_wr = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] pin_is_out = '0;
    logic [31:0] pin_native = '0;
    logic [31:0] pin_level = '0;
    logic [31:0] pad_oe;
    logic [31:0] pad_do;

    int checks = 0;
    int fails  = 0;
    int k      = 0;

    always #2 clk = ~clk;

    gpio_blink_ovl #(
        .PINS(PINS), .BLINK_DEFAULT(DEF), .HALF_CYCLES(HALF),
        .SER_DIV(SDIV), .SER_LEN(SLEN), .SER_PATTERN(PAT)
    ) dut (.*);

    // Cycles since the last restore, from the requirements of R2 and R5.
    always @(posedge clk) begin
        if (!rst_n || rst_ctl_wr) k <= 0;
        else                      k <= k + 1;
    end

    function automatic logic exp_phase();
        return ((k / HALF) % 2) == 0;
    endfunction

    function automatic logic exp_ser();
        return PAT[(k / SDIV) % SLEN];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_word(input logic sel, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd_word(input logic sel, output logic [31:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_sel = sel;
        @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
    endtask

    task automatic t_reset_defaults();
        logic [31:0] d;
        pin_is_out = 32'h0004_0000;
        rd_word(1'b0, d); chk("R1 blink default", d, DEF);
        rd_word(1'b1, d); chk("R1 serial default", d, 32'h0);
        chk("R1 pin18 blinks", {31'b0, pad_do[18]}, {31'b0, exp_phase()});
    endtask

    task automatic t_blink_wave();
        wr_word(1'b0, DEF | 32'h8);
        pin_is_out = 32'h0004_0008;
        for (int i = 0; i < 3 * 2 * HALF; i++) begin
            @(negedge clk);
            chk("R2 oe", {31'b0, pad_oe[3]}, 32'h1);
            chk("R2 wave", {31'b0, pad_do[3]}, {31'b0, exp_phase()});
            chk("R2 in phase", {31'b0, pad_do[18]}, {31'b0, pad_do[3]});
        end
    endtask

    task automatic t_input_ignored();
        wr_word(1'b1, 32'h0000_0100);
        wr_word(1'b0, DEF | 32'h0000_0200);
        pin_is_out = '0; pin_level = 32'h0000_0300;
        for (int i = 0; i < 2 * HALF; i++) begin
            @(negedge clk);
            chk("R3 input oe", pad_oe & 32'h0004_0300, 32'h0);
            chk("R3 input do", pad_do & 32'h300, 32'h300);
        end
    endtask

    task automatic t_level_independent();
        wr_word(1'b0, 32'h10); wr_word(1'b1, 32'h0);
        pin_is_out = 32'h10;
        for (int i = 0; i < 2 * HALF; i++) begin
            @(negedge clk); pin_level[4] = i[0];
            #0.1 chk("R4 level ignored", {31'b0, pad_do[4]}, {31'b0, exp_phase()});
        end
        pin_level[4] = 1'b1;
        wr_word(1'b0, 32'h0);
        chk("R4 level back", {31'b0, pad_do[4]}, 32'h1);
        pin_level[4] = 1'b0; #0.1;
        chk("R4 level back low", {31'b0, pad_do[4]}, 32'h0);
    endtask

    task automatic t_serial_pattern();
        wr_word(1'b1, 32'h20);
        pin_is_out = 32'h20; pin_level = 32'h20;
        for (int i = 0; i < 2 * SDIV * SLEN; i++) begin
            @(negedge clk);
            chk("R5 serial do", {31'b0, pad_do[5]}, 32'h0);
            chk("R5 serial oe", {31'b0, pad_oe[5]}, {31'b0, ~exp_ser()});
        end
    endtask

    task automatic t_priority();
        wr_word(1'b1, 32'h0004_0000); wr_word(1'b0, DEF);
        pin_is_out = 32'h0004_0000;
        for (int i = 0; i < 2 * HALF; i++) begin
            @(negedge clk);
            chk("R6 blink wins oe", {31'b0, pad_oe[18]}, 32'h1);
            chk("R6 blink wins do", {31'b0, pad_do[18]}, {31'b0, exp_phase()});
        end
    endtask

    task automatic t_native();
        logic [31:0] d;
        wr_word(1'b1, 32'h0);
        @(negedge clk); pin_native = 32'h80;
        wr_word(1'b1, 32'h80);
        rd_word(1'b1, d); chk("R7 native read", d, 32'h0);
        @(negedge clk); pin_native = 32'h0;
        rd_word(1'b1, d); chk("R7 native write ignored", d, 32'h0);
        wr_word(1'b0, 32'h80); wr_word(1'b1, 32'h0);
        @(negedge clk); pin_native = 32'h80; pin_is_out = 32'h80; pin_level = 32'h0;
        for (int i = 0; i < 2 * HALF; i++) begin
            @(negedge clk);
            chk("R7 native bypass", {30'b0, pad_oe[7], pad_do[7]}, 32'h2);
        end
        pin_native = 32'h0;
    endtask

    task automatic t_rstctl();
        logic [31:0] d;
        wr_word(1'b0, 32'h0); wr_word(1'b1, 32'h20);
        pin_is_out = 32'h0004_0000;
        repeat (HALF + 1) @(negedge clk);
        rst_ctl_wr = 1'b1; reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 32'hFF;
        @(negedge clk); rst_ctl_wr = 1'b0; reg_wr = 1'b0;
        for (int i = 0; i < HALF; i++) begin
            chk("R8 first half high", {31'b0, pad_do[18]}, 32'h1);
            @(negedge clk);
        end
        chk("R8 second half low", {31'b0, pad_do[18]}, 32'h0);
        rd_word(1'b0, d); chk("R8 blink restored", d, DEF);
        rd_word(1'b1, d); chk("R8 serial restored", d, 32'h0);
    endtask

    task automatic t_plat_reset();
        logic [31:0] d;
        wr_word(1'b0, 32'h8);
        rd_word(1'b0, d); chk("R11 write blink", d, 32'h8);
        pin_is_out = 32'h8;
        @(negedge clk); plat_rst_n = 1'b0;
        @(negedge clk); chk("R9 rdata cleared", reg_rdata, 32'h0);
        @(negedge clk); plat_rst_n = 1'b1;
        chk("R9 phase kept", {31'b0, pad_do[3]}, {31'b0, exp_phase()});
        rd_word(1'b0, d); chk("R9 blink kept", d, 32'h8);
    endtask

    task automatic t_readback();
        logic [31:0] d;
        wr_word(1'b1, 32'hA5A5_0000);
        rd_word(1'b1, d); chk("R10 read serial", d, 32'hA5A5_0000);
        repeat (3) @(negedge clk);
        chk("R10 rdata held", reg_rdata, 32'hA5A5_0000);
        rd_word(1'b0, d); chk("R10 read blink", d, 32'h8);
        wr_word(1'b0, 32'h1234_5678);
        rd_word(1'b0, d); chk("R11 write blink word", d, 32'h1234_5678);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_defaults();
        t_blink_wave();
        t_input_ignored();
        t_level_independent();
        t_serial_pattern();
        t_priority();
        t_native();
        t_rstctl();
        t_plat_reset();
        t_readback();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule